// File: doc/BRIEF.md
# Dual-Compare Timer with PWM Output

This block is a 10-bit up-counter with two compare values and one output pin. Compare A can restart the count, which sets the period. Compare B is the only event that moves the pin. Each compare and the counter wrap raise sticky interrupt flags. Software clears these flags by writing ones to them.

A small write-only register port sets up the block. One control word selects the operating mode, the action taken on a compare-B match, pin inversion and the level the pin starts from. Three modes exist:
- **Compare-match output:** the pin reacts to compare-B matches.
- **Timer/counter:** the flags still work, but the pin is marked unused and held low.
- **PWM:** the pin is active while the count is below compare B. With the clear option set, compare A fixes the period.

The enable bit stops the counter and clears it. Each rising edge of enable re-arms the pin to its initial level. A pause bit freezes the count in place.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset the count is 0, all three flags are 0 and the pin is 0. After the write edge that sets enable, one re-arm cycle passes with the count at 0. From then on the count rises by one per clock.
- R2: With clear-on-A set and compare A nonzero, the count returns to 0 on the edge after it equals compare A. The period is therefore compare A + 1 clocks. The A flag is set on that same edge.
- R3: With clear-on-A clear, the count runs to 0x3FF and wraps to 0. The period flag is set on the wrap edge.
- R4: With clear-on-A set, the period flag is never set.
- R5: With clear-on-A set and compare A equal to 0, the counter runs the full 1024-count cycle. The A flag is not set.
- R6: In compare-match mode, the B action code decides what a compare-B match does to the pin level: 00 leaves it, 01 drives it low, 10 drives it high, 11 toggles it. A compare-A match never changes the pin.
- R7: Only a rising edge of enable reloads the pin level from the initial-level bit. Clearing enable leaves the level as it was.
- R8: The invert bit inverts the pin in compare-match and PWM modes. It takes effect on the clock after the write.
- R9: While pause and enable are both set, the count holds its value. Clearing pause resumes counting from that value. Clearing enable sets the count to 0 one clock later.
- R10: When both mode pairs are 11, the block is in timer/counter mode. pin_unused is 1, the pin is 0, and flags are raised as in compare-match mode.
- R11: Flags are sticky. Writing 1 to a bit at address 3 clears that flag (bit0 A, bit1 B, bit2 period) on the write edge. Bits written 0 are untouched.
- R12: When both mode pairs are 10, the block is in PWM mode. While enabled, the pin before inversion is 1 exactly when count < compare B. With clear-on-A set, compare B high clocks occur in every compare A + 1 clocks.
- R13: Register map:
  - Address 0 is the control word: bit0 enable, bit1 pause, bit2 clear-on-A, bits 4:3 A mode pair, bits 6:5 B mode pair, bits 8:7 B action, bit9 invert, bit10 initial level.
  - Address 1 is compare A, address 2 is compare B, and address 3 is the flag clear.
  - Any mode pair combination other than 11/11 or 10/10 selects compare-match mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 11 | Register write data |
| count | output | 10 | Current counter value |
| pin | output | 1 | Timer output pin |
| pin_unused | output | 1 | High when the pin is not used (timer/counter mode) |
| irq_a | output | 1 | Sticky compare-A flag |
| irq_b | output | 1 | Sticky compare-B flag |
| irq_p | output | 1 | Sticky period (wrap) flag |

## Verification
The bench targets the corner cases where timer logic usually goes wrong:
- **Compare A equal to zero with clear-on-A set:** a wrong design clears the count on every clock or flags A on the wrap. The bench expects a 1024-count run with no A flag.
- **Period flag under clear-on-A:** a wrong design sets the period flag on the A restart or on the full wrap.
- **Re-arm rule:** the level must survive a disable and reload only on the enable rising edge. A wrong design resets the pin when enable falls, or never.
- **Toggle timing with an A match in between:** a wrong design lets compare A move the pin.
- **Pause and resume:** a wrong design drifts the count while paused.
- **PWM high-time count:** an off-by-one in the duty compare shows up as one high clock too many or too few, with and without inversion.

// File: rtl/dct_pkg.sv
package dct_pkg;

  // Control word, MSB first: init_lvl is bit 10, en is bit 0
  typedef struct packed {
    logic       init_lvl;
    logic       pol;
    logic [1:0] bsel;
    logic [1:0] mode_b;
    logic [1:0] mode_a;
    logic       clr_a;
    logic       pause;
    logic       en;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_CMPA = 2'd1;
  localparam logic [1:0] ADDR_CMPB = 2'd2;
  localparam logic [1:0] ADDR_FLAG = 2'd3;

  localparam int N_FLAG = 3;
  localparam int FLAG_A = 0;
  localparam int FLAG_B = 1;
  localparam int FLAG_P = 2;

  typedef enum logic [1:0] {
    OPM_CMP = 2'd0,
    OPM_TMR = 2'd1,
    OPM_PWM = 2'd2
  } opmode_e;

  function automatic opmode_e decode_mode(input logic [1:0] ma, input logic [1:0] mb);
    if (ma == 2'b11 && mb == 2'b11) return OPM_TMR;
    if (ma == 2'b10 && mb == 2'b10) return OPM_PWM;
    return OPM_CMP;
  endfunction

  // Level after a compare-B match, from the current level and the action code
  function automatic logic match_level(input logic cur, input logic [1:0] sel);
    case (sel)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction

endpackage

// File: rtl/dct_regs.sv
module dct_regs
  import dct_pkg::*;
#(
  parameter int CNT_W  = 10,
  parameter int DATA_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output ctrl_t             ctrl_q,
  output logic [CNT_W-1:0]  cmp_a_q,
  output logic [CNT_W-1:0]  cmp_b_q,
  output logic [N_FLAG-1:0] flag_w1c
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      cmp_a_q <= '0;
      cmp_b_q <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_CTRL: ctrl_q  <= ctrl_t'(wr_data[CTRL_W-1:0]);
        ADDR_CMPA: cmp_a_q <= wr_data[CNT_W-1:0];
        ADDR_CMPB: cmp_b_q <= wr_data[CNT_W-1:0];
        default:   ;
      endcase
    end
  end

  always_comb begin
    flag_w1c = '0;
    if (wr_en && wr_addr == ADDR_FLAG) flag_w1c = wr_data[N_FLAG-1:0];
  end

endmodule

// File: rtl/dct_counter.sv
module dct_counter #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             pause,
  input  logic             clr_a,
  input  logic [CNT_W-1:0] cmp_a,
  input  logic [CNT_W-1:0] cmp_b,
  output logic [CNT_W-1:0] count,
  output logic             en_rise,
  output logic             run,
  output logic             hit_a,
  output logic             hit_b,
  output logic             wrap_p
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic en_d;
  logic restart;

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c, input logic rst_now);
    return rst_now ? '0 : c + 1'b1;
  endfunction

  assign en_rise = en & ~en_d;
  assign run     = en & en_d & ~pause;
  assign restart = clr_a && (cmp_a != '0) && (count == cmp_a);
  assign hit_a   = run && (count == cmp_a) && !(clr_a && cmp_a == '0);
  assign hit_b   = run && (count == cmp_b);
  assign wrap_p  = run && (count == CNT_MAX) && !clr_a;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_d  <= 1'b0;
      count <= '0;
    end else begin
      en_d <= en;
      if (!en)      count <= '0;
      else if (run) count <= next_count(count, restart);
    end
  end

endmodule

// File: rtl/dct_flags.sv
module dct_flags
  import dct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_FLAG-1:0] set_evt,
  input  logic [N_FLAG-1:0] clr_req,
  output logic [N_FLAG-1:0] flags
);

  logic [N_FLAG-1:0] nxt;

  for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
    assign nxt[i] = set_evt[i] | (flags[i] & ~clr_req[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flags <= '0;
    else        flags <= nxt;
  end

endmodule

// File: rtl/dct_outgen.sv
module dct_outgen
  import dct_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  opmode_e          mode,
  input  logic [1:0]       bsel,
  input  logic             pol,
  input  logic             init_lvl,
  input  logic             en,
  input  logic             en_rise,
  input  logic             hit_b,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] cmp_b,
  output logic             level_q,
  output logic             pin,
  output logic             pin_unused
);

  function automatic logic pwm_active(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] duty);
    return c < duty;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)                           level_q <= 1'b0;
    else if (en_rise)                     level_q <= init_lvl;
    else if (hit_b && mode != OPM_PWM)    level_q <= match_level(level_q, bsel);
  end

  always_comb begin
    pin_unused = (mode == OPM_TMR);
    case (mode)
      OPM_TMR: pin = 1'b0;
      OPM_PWM: pin = (en & pwm_active(count, cmp_b)) ^ pol;
      default: pin = level_q ^ pol;
    endcase
  end

endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import dct_pkg::*;
#(
  parameter  int CNT_W  = 10,
  localparam int DATA_W = (CNT_W > CTRL_W) ? CNT_W : CTRL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [CNT_W-1:0]  count,
  output logic              pin,
  output logic              pin_unused,
  output logic              irq_a,
  output logic              irq_b,
  output logic              irq_p
);

  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  cmp_a_q;
  logic [CNT_W-1:0]  cmp_b_q;
  logic [N_FLAG-1:0] flag_w1c;
  logic [N_FLAG-1:0] flag_set;
  logic [N_FLAG-1:0] flags;
  logic              en_rise, run, hit_a, hit_b, wrap_p, level_q;
  opmode_e           mode;

  // named configuration wires for the checker
  logic       cfg_en, cfg_pause, cfg_clr_a, cfg_pol, cfg_init;
  logic [1:0] cfg_bsel, cfg_ma, cfg_mb;

  assign cfg_en    = ctrl_q.en;
  assign cfg_pause = ctrl_q.pause;
  assign cfg_clr_a = ctrl_q.clr_a;
  assign cfg_pol   = ctrl_q.pol;
  assign cfg_init  = ctrl_q.init_lvl;
  assign cfg_bsel  = ctrl_q.bsel;
  assign cfg_ma    = ctrl_q.mode_a;
  assign cfg_mb    = ctrl_q.mode_b;
  assign mode      = decode_mode(cfg_ma, cfg_mb);

  dct_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .cmp_a_q(cmp_a_q), .cmp_b_q(cmp_b_q), .flag_w1c(flag_w1c)
  );

  dct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .pause(cfg_pause), .clr_a(cfg_clr_a),
    .cmp_a(cmp_a_q), .cmp_b(cmp_b_q), .count(count), .en_rise(en_rise), .run(run),
    .hit_a(hit_a), .hit_b(hit_b), .wrap_p(wrap_p)
  );

  assign flag_set[FLAG_A] = hit_a;
  assign flag_set[FLAG_B] = hit_b;
  assign flag_set[FLAG_P] = wrap_p;

  dct_flags u_flags (
    .clk(clk), .rst_n(rst_n), .set_evt(flag_set), .clr_req(flag_w1c), .flags(flags)
  );

  assign irq_a = flags[FLAG_A];
  assign irq_b = flags[FLAG_B];
  assign irq_p = flags[FLAG_P];

  dct_outgen #(.CNT_W(CNT_W)) u_out (
    .clk(clk), .rst_n(rst_n), .mode(mode), .bsel(cfg_bsel), .pol(cfg_pol),
    .init_lvl(cfg_init), .en(cfg_en), .en_rise(en_rise), .hit_b(hit_b),
    .count(count), .cmp_b(cmp_b_q), .level_q(level_q), .pin(pin), .pin_unused(pin_unused)
  );

endmodule

// File: rtl/dct_checker.sv
module dct_checker #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             pause,
  input logic             clr_a,
  input logic             pol,
  input logic             init_lvl,
  input logic [1:0]       bsel,
  input logic [1:0]       mode_a,
  input logic [1:0]       mode_b,
  input logic [CNT_W-1:0] cmp_a,
  input logic [CNT_W-1:0] cmp_b,
  input logic [CNT_W-1:0] count,
  input logic             run,
  input logic             hit_a,
  input logic             hit_b,
  input logic             level_q,
  input logic             pin,
  input logic             pin_unused,
  input logic             flag_a,
  input logic             flag_p
);

  logic cmp_mode, tmr_mode, pwm_mode;
  assign tmr_mode = (mode_a == 2'b11) && (mode_b == 2'b11);
  assign pwm_mode = (mode_a == 2'b10) && (mode_b == 2'b10);
  assign cmp_mode = !tmr_mode && !pwm_mode;

  assert_clear_on_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && clr_a && cmp_a != '0 && count == cmp_a) |=> (count == '0));

  assert_no_period_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_p) |-> !$past(clr_a));

  assert_zero_cmpa_no_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_a) |-> !($past(clr_a) && $past(cmp_a) == '0));

  assert_toggle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_mode && hit_b && bsel == 2'b11) |=> (level_q != $past(level_q)));

  assert_rearm_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |=> (level_q == $past(init_lvl)));

  assert_pause_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && pause) |=> $stable(count));

  assert_disable_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (count == '0));

  assert_timer_pin_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_mode |-> (pin_unused && !pin));

  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    hit_a |=> flag_a);

  assert_pwm_level_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && en) |-> (pin == ((count < cmp_b) ^ pol)));

endmodule

bind dual_cmp_timer dct_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(cfg_en), .pause(cfg_pause), .clr_a(cfg_clr_a),
  .pol(cfg_pol), .init_lvl(cfg_init), .bsel(cfg_bsel), .mode_a(cfg_ma), .mode_b(cfg_mb),
  .cmp_a(cmp_a_q), .cmp_b(cmp_b_q), .count(count), .run(run), .hit_a(hit_a),
  .hit_b(hit_b), .level_q(level_q), .pin(pin), .pin_unused(pin_unused),
  .flag_a(irq_a), .flag_p(irq_p)
);

// File: tb/dual_cmp_timer_test.sv
module dual_cmp_timer_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [10:0] wr_data = '0;
  logic [9:0]  count;
  logic        pin, pin_unused, irq_a, irq_b, irq_p;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  dual_cmp_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .count(count), .pin(pin), .pin_unused(pin_unused),
    .irq_a(irq_a), .irq_b(irq_b), .irq_p(irq_p)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [10:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [10:0] mk_ctrl(input logic en, input logic pause, input logic clr,
                                          input logic [1:0] ma, input logic [1:0] mb,
                                          input logic [1:0] bsel, input logic pol, input logic init);
    return {init, pol, bsel, mb, ma, clr, pause, en};
  endfunction

  task automatic stop_all();
    wr(2'd0, 11'd0);
    wr(2'd3, 11'd7);
  endtask

  task automatic t_reset();
    chk("R1 reset count", count, 0);
    chk("R1 reset flags", {irq_p, irq_b, irq_a}, 0);
    chk("R1 reset pin", pin, 0);
    chk("R1 reset pin_unused", pin_unused, 0);
  endtask

  task automatic t_wrap();
    stop_all();
    wr(2'd1, 11'd5);
    wr(2'd2, 11'd900);
    wr(2'd0, mk_ctrl(1, 0, 0, 2'b00, 2'b00, 2'b00, 0, 0));
    tick(11);
    chk("R1 count after 11 clocks", count, 10);
    tick(1013);
    chk("R3 count at max", count, 1023);
    chk("R3 period flag before wrap", irq_p, 0);
    tick(1);
    chk("R3 count wrapped", count, 0);
    chk("R3 period flag on wrap", irq_p, 1);
    chk("R2 A flag without clear", irq_a, 1);
    // R11: clear only the A flag
    wr(2'd0, 11'd0);
    wr(2'd3, 11'd1);
    chk("R11 A flag cleared", irq_a, 0);
    chk("R11 period flag kept", irq_p, 1);
    chk("R11 B flag kept", irq_b, 1);
    wr(2'd3, 11'd6);
    chk("R11 remaining flags cleared", {irq_p, irq_b}, 0);
  endtask

  task automatic t_clear_a();
    stop_all();
    wr(2'd1, 11'd9);
    wr(2'd2, 11'd1000);
    wr(2'd0, mk_ctrl(1, 0, 1, 2'b00, 2'b00, 2'b00, 0, 0));
    tick(10);
    chk("R2 count at compare A", count, 9);
    chk("R2 A flag not yet", irq_a, 0);
    tick(1);
    chk("R2 count restarted", count, 0);
    chk("R2 A flag set", irq_a, 1);
    tick(1100);
    chk("R4 no period flag with clear-on-A", irq_p, 0);
  endtask

  task automatic t_zero_a();
    stop_all();
    wr(2'd1, 11'd0);
    wr(2'd2, 11'd1000);
    wr(2'd0, mk_ctrl(1, 0, 1, 2'b00, 2'b00, 2'b00, 0, 0));
    tick(1024);
    chk("R5 full run to max", count, 1023);
    tick(1);
    chk("R5 wrapped", count, 0);
    tick(5);
    chk("R5 no A flag", irq_a, 0);
    chk("R5 no period flag", irq_p, 0);
  endtask

  task automatic t_toggle();
    stop_all();
    wr(2'd1, 11'd7);
    wr(2'd2, 11'd3);
    wr(2'd0, mk_ctrl(1, 0, 1, 2'b00, 2'b00, 2'b11, 0, 0));
    tick(4);
    chk("R6 toggle before match", pin, 0);
    tick(1);
    chk("R6 toggle after first match", pin, 1);
    tick(7);
    chk("R6 compare A does not move pin", pin, 1);
    tick(1);
    chk("R6 toggle after second match", pin, 0);
  endtask

  task automatic t_set_high_rearm();
    stop_all();
    wr(2'd1, 11'd5);
    wr(2'd2, 11'd2);
    wr(2'd0, mk_ctrl(1, 0, 1, 2'b00, 2'b00, 2'b10, 0, 0));
    tick(3);
    chk("R6 set-high before match", pin, 0);
    tick(1);
    chk("R6 set-high after match", pin, 1);
    tick(26);
    chk("R6 stays high", pin, 1);
    wr(2'd0, mk_ctrl(0, 0, 1, 2'b00, 2'b00, 2'b10, 0, 0));
    tick(3);
    chk("R7 disable keeps level", pin, 1);
    wr(2'd0, mk_ctrl(1, 0, 1, 2'b00, 2'b00, 2'b10, 0, 0));
    tick(1);
    chk("R7 enable rise reloads low", pin, 0);
  endtask

  task automatic t_drive_low();
    stop_all();
    wr(2'd1, 11'd5);
    wr(2'd2, 11'd2);
    wr(2'd0, mk_ctrl(1, 0, 1, 2'b00, 2'b00, 2'b01, 0, 1));
    tick(1);
    chk("R7 initial level high", pin, 1);
    tick(3);
    chk("R6 drive-low after match", pin, 0);
  endtask

  task automatic t_polarity();
    stop_all();
    wr(2'd2, 11'd1000);
    wr(2'd0, mk_ctrl(1, 0, 0, 2'b00, 2'b00, 2'b00, 0, 1));
    tick(1);
    chk("R8 level high uninverted", pin, 1);
    wr(2'd0, mk_ctrl(1, 0, 0, 2'b00, 2'b00, 2'b00, 1, 1));
    chk("R8 inverted", pin, 0);
  endtask

  task automatic t_pause();
    int c1;
    stop_all();
    wr(2'd2, 11'd1000);
    wr(2'd0, mk_ctrl(1, 0, 0, 2'b00, 2'b00, 2'b00, 0, 0));
    tick(20);
    wr(2'd0, mk_ctrl(1, 1, 0, 2'b00, 2'b00, 2'b00, 0, 0));
    c1 = int'(count);
    tick(20);
    chk("R9 paused count held", count, c1);
    wr(2'd0, mk_ctrl(1, 0, 0, 2'b00, 2'b00, 2'b00, 0, 0));
    tick(5);
    chk("R9 resume from held value", count, c1 + 5);
    wr(2'd0, mk_ctrl(0, 0, 0, 2'b00, 2'b00, 2'b00, 0, 0));
    tick(1);
    chk("R9 disable clears count", count, 0);
  endtask

  task automatic t_timer();
    int highs = 0;
    stop_all();
    wr(2'd1, 11'd9);
    wr(2'd2, 11'd4);
    wr(2'd0, mk_ctrl(1, 0, 1, 2'b11, 2'b11, 2'b11, 0, 0));
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (pin) highs++;
    end
    chk("R10 pin_unused", pin_unused, 1);
    chk("R10 pin held low", highs, 0);
    chk("R10 B flag raised", irq_b, 1);
    chk("R10 A flag raised", irq_a, 1);
  endtask

  task automatic t_pwm();
    int highs = 0;
    stop_all();
    wr(2'd1, 11'd9);
    wr(2'd2, 11'd3);
    wr(2'd0, mk_ctrl(1, 0, 1, 2'b10, 2'b10, 2'b10, 0, 0));
    chk("R12 pwm pin_unused", pin_unused, 0);
    tick(20);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (pin) highs++;
    end
    chk("R12 duty high clocks per period", highs, 3);
    wr(2'd0, mk_ctrl(1, 0, 1, 2'b10, 2'b10, 2'b10, 1, 0));
    highs = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (pin) highs++;
    end
    chk("R12 R8 inverted duty", highs, 7);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_wrap();
    t_clear_a();
    t_zero_a();
    t_toggle();
    t_set_high_rearm();
    t_drive_low();
    t_polarity();
    t_pause();
    t_timer();
    t_pwm();
    // R13: register map exercised by every scenario above
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule